// File: doc/BRIEF.md
# Multi-Rate Serial TDM Stream Port

This block terminates up to eight serial time-division-multiplexed lines. A frame counter, kept in step by an 8 kHz frame pulse, divides each 125 us frame into channels of eight bits. It runs at one of three rates: 32, 64 or 128 channels per line per frame. At the two lower rates all eight lines carry traffic. At the highest rate only lines 0 to 3 do, so a frame never holds more than 512 channels.

Each line's direction is set channel by channel from a table. In an output channel the block drives a byte from the switching side onto the line, most significant bit first. In an input channel it releases the driver, shifts in the incoming byte and hands it over in parallel, tagged with its line and channel. The bit clock comes from either an internal strobe or an external reference strobe. The external strobe is used only when the reference-enable input is high and the internal-clock input is low.

Top module: `tdm_stream_port`

## Requirements
- R1: `rate_i` 0 gives 32 channels per frame, 1 gives 64 and 2 gives 128 (3 behaves as 0). A new rate takes effect only at a frame pulse. Without a pulse, the channel index wraps from the last channel back to 0, and `rx_chan_o` is always below the channel count.
- R2: A bit tick with `fp_i` high starts bit 0 of channel 0 at any point in the frame. A partly received channel is then dropped.
- R3: During bit b (0..7) of an output channel, `sdo_o[s]` carries bit 7-b of the byte. That byte is `tx_data_i[8s+7:8s]`, sampled at the tick that starts the channel, and `tx_chan_o` names that channel.
- R4: Bit s of the table word written for channel c (`dir_lines_i`, 1 = output) sets the direction of line s in channel c. `sdo_oe_o[s]` holds one value for all eight bit times of the channel. A table write takes effect from the next channel start.
- R5: In an input channel on an active line, the bits sampled on `sdi_i[s]` at the eight ticks ending the channel arrive in `rx_data_o[8s+7:8s]`, first bit as MSB. `rx_valid_o[s]` pulses for one clock after the tick that ends bit 7, and `rx_chan_o` gives the channel. No pulse appears for output channels.
- R6: While rate 2 is in effect, lines 4 to 7 are never driven and their inputs produce no data.
- R7: After reset every table entry is input, and all outputs stay released with no received data until the first frame pulse.
- R8: The external tick drives the counters only when `ref_en_i` is 1 and `int_clk_i` is 0. Otherwise the internal tick drives them, and pulses on the unselected source change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_en_i | input | 1 | Allow the external reference tick |
| int_clk_i | input | 1 | Force the internal tick |
| ext_tick_i | input | 1 | External bit-clock strobe |
| int_tick_i | input | 1 | Internal bit-clock strobe |
| fp_i | input | 1 | Frame pulse, sampled on a bit tick |
| rate_i | input | 2 | Rate select |
| dir_we_i | input | 1 | Direction table write |
| dir_chan_i | input | 7 | Channel written |
| dir_lines_i | input | 8 | Per-line direction word, 1 = output |
| tx_data_i | input | 64 | Byte per line for channel `tx_chan_o` |
| tx_chan_o | output | 7 | Channel that the next channel start loads |
| sdi_i | input | 8 | Serial line inputs |
| sdo_o | output | 8 | Serial line output data |
| sdo_oe_o | output | 8 | Output driver enables |
| rx_valid_o | output | 8 | Received byte strobe per line |
| rx_data_o | output | 64 | Received bytes, line s in bits 8s+7:8s |
| rx_chan_o | output | 7 | Channel of the received bytes |

## Verification
The bench goes after the free-running wrap at each rate. A counter that wrapped at the wrong count would shift every later byte into the wrong channel. It issues a frame pulse in the middle of a channel, where a design that failed to realign would send stale bits or report a truncated byte. It changes the rate a few ticks before a frame pulse, which catches a design that switches channel count in mid-frame. At the highest rate it checks that lines 4 to 7 stay released and silent, and it pulses the unselected tick source to expose a design that counts both.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;

    localparam int unsigned FRAME_CAP = 512;

    typedef enum logic [1:0] {
        RATE_LOW  = 2'd0,
        RATE_MID  = 2'd1,
        RATE_HIGH = 2'd2
    } rate_e;

    // Code 3 is not a rate of its own; it falls back to the lowest one.
    function automatic rate_e norm_rate(input logic [1:0] code);
        return (code == 2'd3) ? RATE_LOW : rate_e'(code);
    endfunction

    function automatic int unsigned chans_for(input rate_e r, input int unsigned base);
        case (r)
            RATE_MID:  return base * 2;
            RATE_HIGH: return base * 4;
            default:   return base;
        endcase
    endfunction

    function automatic int unsigned lines_for(input rate_e r, input int unsigned lines);
        return (r == RATE_HIGH) ? lines / 2 : lines;
    endfunction

endpackage

// File: rtl/tdm_tick_sel.sv
module tdm_tick_sel (
    input  logic ref_en_i,
    input  logic int_clk_i,
    input  logic ext_tick_i,
    input  logic int_tick_i,
    output logic tick_o
);
    logic ext_sel;

    always_comb begin
        ext_sel = ref_en_i && !int_clk_i;
        tick_o  = ext_sel ? ext_tick_i : int_tick_i;
    end
endmodule

// File: rtl/tdm_slot_ctr.sv
module tdm_slot_ctr
    import tdm_port_pkg::*;
#(
    parameter int BASE_CH = 32,
    parameter int CH_W    = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_i,
    input  logic            fp_i,
    input  logic [1:0]      rate_i,
    output logic [CH_W-1:0] chan_o,
    output logic [2:0]      bit_o,
    output rate_e           rate_o,
    output logic            synced_o,
    output logic [2:0]      nbit_o,
    output rate_e           nrate_o,
    output logic            nsynced_o,
    output logic            chan_start_o,
    output logic [CH_W-1:0] tx_chan_o
);
    typedef struct packed {
        logic [CH_W-1:0] chan;
        logic [2:0]      bitn;
        rate_e           rate;
        logic            synced;
    } ctr_t;

    ctr_t q, d;
    logic [CH_W-1:0] last_chan;
    logic            at_last;

    always_comb begin
        d         = q;
        last_chan = CH_W'(chans_for(q.rate, BASE_CH) - 1);
        at_last   = (q.chan >= last_chan);
        tx_chan_o = fp_i ? '0 : (at_last ? '0 : q.chan + 1'b1);
        chan_start_o = tick_i && (fp_i || q.bitn == 3'd7);
        if (tick_i) begin
            if (fp_i) begin
                d.chan   = '0;
                d.bitn   = 3'd0;
                d.rate   = norm_rate(rate_i);
                d.synced = 1'b1;
            end else if (q.bitn == 3'd7) begin
                d.bitn = 3'd0;
                d.chan = at_last ? '0 : q.chan + 1'b1;
            end else begin
                d.bitn = q.bitn + 3'd1;
            end
        end
        chan_o    = q.chan;
        bit_o     = q.bitn;
        rate_o    = q.rate;
        synced_o  = q.synced;
        nbit_o    = d.bitn;
        nrate_o   = d.rate;
        nsynced_o = d.synced;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{chan: '0, bitn: 3'd0, rate: RATE_LOW, synced: 1'b0};
        end else begin
            q <= d;
        end
    end

    p_chan_in_range_r1: assert property (@(posedge clk) disable iff (rst)
        32'(q.chan) < chans_for(q.rate, BASE_CH));

    p_bit_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        tick_i && !fp_i && q.bitn == 3'd7 |=> q.bitn == 3'd0);

    p_frame_align_r2: assert property (@(posedge clk) disable iff (rst)
        tick_i && fp_i |=> q.chan == '0 && q.bitn == 3'd0 && q.synced);
endmodule

// File: rtl/tdm_dir_table.sv
module tdm_dir_table #(
    parameter int LINES  = 8,
    parameter int CH_W   = 7,
    localparam int MAX_CH = 1 << CH_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [CH_W-1:0]  wchan_i,
    input  logic [LINES-1:0] wdata_i,
    input  logic [CH_W-1:0]  rchan_i,
    output logic [LINES-1:0] rdata_o
);
    logic [LINES-1:0] mem_q [MAX_CH];
    logic [LINES-1:0] mem_d [MAX_CH];

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[wchan_i] = wdata_i;
        end
        rdata_o = mem_q[rchan_i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAX_CH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    p_table_write_r4: assert property (@(posedge clk) disable iff (rst)
        we_i |=> mem_q[$past(wchan_i)] == $past(wdata_i));
endmodule

// File: rtl/tdm_lane.sv
module tdm_lane (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       chan_start_i,
    input  logic [2:0] bit_i,
    input  logic [2:0] nbit_i,
    input  logic       synced_i,
    input  logic       nsynced_i,
    input  logic       act_next_i,
    input  logic       dir_next_i,
    input  logic [7:0] tx_byte_i,
    input  logic       sdi_i,
    output logic       sdo_o,
    output logic       oe_o,
    output logic       rx_valid_o,
    output logic [7:0] rx_byte_o
);
    typedef struct packed {
        logic [7:0] tx_byte;
        logic       dir_cur;
        logic       act_cur;
        logic       sdo;
        logic       oe;
        logic [6:0] rx_sh;
        logic       rx_valid;
        logic [7:0] rx_byte;
    } lane_t;

    lane_t q, d;

    always_comb begin
        d          = q;
        d.rx_valid = 1'b0;
        if (tick_i) begin
            if (synced_i && bit_i == 3'd7 && q.act_cur && !q.dir_cur) begin
                d.rx_valid = 1'b1;
                d.rx_byte  = {q.rx_sh, sdi_i};
            end
            d.rx_sh = {q.rx_sh[5:0], sdi_i};
            if (chan_start_i) begin
                d.tx_byte = tx_byte_i;
                d.dir_cur = dir_next_i;
                d.act_cur = act_next_i;
            end
            d.oe  = nsynced_i && d.act_cur && d.dir_cur;
            d.sdo = d.oe ? d.tx_byte[3'd7 - nbit_i] : 1'b0;
        end
        sdo_o      = q.sdo;
        oe_o       = q.oe;
        rx_valid_o = q.rx_valid;
        rx_byte_o  = q.rx_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    p_oe_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !chan_start_i |=> $stable(oe_o));

    p_hiz_unsynced_r7: assert property (@(posedge clk) disable iff (rst)
        !synced_i |-> !oe_o && !rx_valid_o);
endmodule

// File: rtl/tdm_stream_port.sv
module tdm_stream_port
    import tdm_port_pkg::*;
#(
    parameter int LINES   = 8,
    parameter int BASE_CH = 32,
    localparam int CH_W   = $clog2(BASE_CH * 4)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_en_i,
    input  logic               int_clk_i,
    input  logic               ext_tick_i,
    input  logic               int_tick_i,
    input  logic               fp_i,
    input  logic [1:0]         rate_i,
    input  logic               dir_we_i,
    input  logic [CH_W-1:0]    dir_chan_i,
    input  logic [LINES-1:0]   dir_lines_i,
    input  logic [LINES*8-1:0] tx_data_i,
    output logic [CH_W-1:0]    tx_chan_o,
    input  logic [LINES-1:0]   sdi_i,
    output logic [LINES-1:0]   sdo_o,
    output logic [LINES-1:0]   sdo_oe_o,
    output logic [LINES-1:0]   rx_valid_o,
    output logic [LINES*8-1:0] rx_data_o,
    output logic [CH_W-1:0]    rx_chan_o
);
    logic            tick;
    logic [CH_W-1:0] chan;
    logic [2:0]      bitn, nbit;
    rate_e           rate_q, nrate;
    logic            synced, nsynced, chan_start;
    logic [LINES-1:0] dir_next, act_next;
    logic [CH_W-1:0] rx_chan_q, rx_chan_d;

    tdm_tick_sel u_tick_sel (
        .ref_en_i   (ref_en_i),
        .int_clk_i  (int_clk_i),
        .ext_tick_i (ext_tick_i),
        .int_tick_i (int_tick_i),
        .tick_o     (tick)
    );

    tdm_slot_ctr #(.BASE_CH(BASE_CH), .CH_W(CH_W)) u_ctr (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick),
        .fp_i         (fp_i),
        .rate_i       (rate_i),
        .chan_o       (chan),
        .bit_o        (bitn),
        .rate_o       (rate_q),
        .synced_o     (synced),
        .nbit_o       (nbit),
        .nrate_o      (nrate),
        .nsynced_o    (nsynced),
        .chan_start_o (chan_start),
        .tx_chan_o    (tx_chan_o)
    );

    tdm_dir_table #(.LINES(LINES), .CH_W(CH_W)) u_dir (
        .clk     (clk),
        .rst     (rst),
        .we_i    (dir_we_i),
        .wchan_i (dir_chan_i),
        .wdata_i (dir_lines_i),
        .rchan_i (tx_chan_o),
        .rdata_o (dir_next)
    );

    for (genvar s = 0; s < LINES; s++) begin : g_lane
        assign act_next[s] = (32'(s) < lines_for(nrate, LINES));

        tdm_lane u_lane (
            .clk          (clk),
            .rst          (rst),
            .tick_i       (tick),
            .chan_start_i (chan_start),
            .bit_i        (bitn),
            .nbit_i       (nbit),
            .synced_i     (synced),
            .nsynced_i    (nsynced),
            .act_next_i   (act_next[s]),
            .dir_next_i   (dir_next[s]),
            .tx_byte_i    (tx_data_i[s*8 +: 8]),
            .sdi_i        (sdi_i[s]),
            .sdo_o        (sdo_o[s]),
            .oe_o         (sdo_oe_o[s]),
            .rx_valid_o   (rx_valid_o[s]),
            .rx_byte_o    (rx_data_o[s*8 +: 8])
        );
    end

    always_comb begin
        rx_chan_d = rx_chan_q;
        if (tick && bitn == 3'd7) begin
            rx_chan_d = chan;
        end
        rx_chan_o = rx_chan_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_chan_q <= '0;
        end else begin
            rx_chan_q <= rx_chan_d;
        end
    end

    always_comb begin
        p_frame_cap_r6: assert (chans_for(rate_q, BASE_CH) * lines_for(rate_q, LINES)
                                <= FRAME_CAP * (BASE_CH / 32) * (LINES / 8) || rst);
    end

    p_upper_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        rate_q == RATE_HIGH |-> sdo_oe_o[LINES-1:LINES/2] == '0);

    p_rx_chan_range_r1: assert property (@(posedge clk) disable iff (rst)
        |rx_valid_o |-> 32'(rx_chan_o) < chans_for(rate_q, BASE_CH) || $past(fp_i));
endmodule

// File: tb/tdm_stream_port_bench.sv
module tdm_stream_port_bench;
    localparam int LINES = 8;
    localparam int CHW   = 7;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1;
    logic ref_en = 1'b0, int_clk = 1'b0, ext_tick = 1'b0, int_tick = 1'b0, fp = 1'b0;
    logic [1:0] rate = 2'd0;
    logic dir_we = 1'b0;
    logic [CHW-1:0] dir_chan = '0;
    logic [LINES-1:0] dir_lines = '0;
    logic [LINES*8-1:0] tx_data;
    logic [CHW-1:0] tx_chan;
    logic [LINES-1:0] sdi = '0;
    logic [LINES-1:0] sdo, sdo_oe, rx_valid;
    logic [LINES*8-1:0] rx_data;
    logic [CHW-1:0] rx_chan;

    tdm_stream_port u_tdm_stream_port (
        .clk(clk), .rst(rst), .ref_en_i(ref_en), .int_clk_i(int_clk),
        .ext_tick_i(ext_tick), .int_tick_i(int_tick), .fp_i(fp), .rate_i(rate),
        .dir_we_i(dir_we), .dir_chan_i(dir_chan), .dir_lines_i(dir_lines),
        .tx_data_i(tx_data), .tx_chan_o(tx_chan), .sdi_i(sdi), .sdo_o(sdo),
        .sdo_oe_o(sdo_oe), .rx_valid_o(rx_valid), .rx_data_o(rx_data), .rx_chan_o(rx_chan)
    );

    int n_cmp = 0, n_bad = 0;
    int bchan = 0, bbit = 0, brate = 0;
    bit bsync = 1'b0, use_ext = 1'b0;
    logic [7:0] bdir [128];
    logic [7:0] cur_dir = '0, cur_act = 8'hFF;
    int txsalt = 0, rxsalt = 0;

    function automatic int exp_chans(input int r);
        return (r == 3) ? 32 : (32 << r);
    endfunction
    function automatic int exp_lines(input int r);
        return (r == 2) ? 4 : 8;
    endfunction
    function automatic logic [7:0] txpat(input int s, input int c, input int salt);
        return 8'((s * 53 + c * 29 + salt) ^ (c >> 1));
    endfunction
    function automatic logic [7:0] rxpat(input int s, input int c, input int salt);
        return 8'(((s * 71) ^ (c * 17)) + salt * 3 + 1);
    endfunction

    always_comb begin
        for (int s = 0; s < LINES; s++) begin
            tx_data[s*8 +: 8] = txpat(s, int'(tx_chan), txsalt);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_tick(input bit with_fp);
        int pchan = bchan, pbit = bbit, psalt = rxsalt;
        logic [7:0] pdir = cur_dir, pact = cur_act;
        bit psync = bsync;
        logic [7:0] b;
        @(negedge clk);
        for (int s = 0; s < LINES; s++) begin
            b = rxpat(s, bchan, rxsalt);
            sdi[s] = b[7 - bbit];
        end
        fp = with_fp;
        if (use_ext) ext_tick = 1'b1; else int_tick = 1'b1;
        if (with_fp) begin
            bchan = 0; bbit = 0; brate = (rate == 2'd3) ? 0 : int'(rate); bsync = 1'b1;
        end else if (bbit == 7) begin
            bbit = 0;
            bchan = (bchan >= exp_chans(brate) - 1) ? 0 : bchan + 1;
        end else begin
            bbit++;
        end
        if (bbit == 0) begin
            cur_dir = bdir[bchan];
            for (int s = 0; s < LINES; s++) cur_act[s] = (s < exp_lines(brate));
        end
        @(negedge clk);
        ext_tick = 1'b0; int_tick = 1'b0; fp = 1'b0;
        for (int s = 0; s < LINES; s++) begin
            bit exp_oe, exp_rv;
            string req;
            exp_oe = bsync && cur_act[s] && cur_dir[s];
            req = !bsync ? "R7" : ((s >= 4 && brate == 2) ? "R6" : "R4");
            check(sdo_oe[s] == exp_oe, req, $sformatf("oe line %0d ch %0d", s, bchan),
                  int'(sdo_oe[s]), int'(exp_oe));
            if (exp_oe) begin
                b = txpat(s, bchan, txsalt);
                check(sdo[s] == b[7 - bbit], "R3", $sformatf("sdo line %0d ch %0d bit %0d", s, bchan, bbit),
                      int'(sdo[s]), int'(b[7 - bbit]));
            end
            exp_rv = psync && pbit == 7 && pact[s] && !pdir[s];
            req = (!psync) ? "R7" : ((s >= 4 && !pact[s]) ? "R6" : "R5");
            check(rx_valid[s] == exp_rv, req, $sformatf("rx_valid line %0d ch %0d", s, pchan),
                  int'(rx_valid[s]), int'(exp_rv));
            if (exp_rv) begin
                b = rxpat(s, pchan, psalt);
                check(rx_data[s*8 +: 8] == b, "R5", $sformatf("rx byte line %0d ch %0d", s, pchan),
                      int'(rx_data[s*8 +: 8]), int'(b));
                check(int'(rx_chan) == pchan, "R1", "rx_chan", int'(rx_chan), pchan);
            end
        end
    endtask

    task automatic write_dirs();
        for (int c = 0; c < 128; c++) begin
            bdir[c] = 8'($urandom);
            @(negedge clk);
            dir_we = 1'b1; dir_chan = CHW'(c); dir_lines = bdir[c];
        end
        @(negedge clk);
        dir_we = 1'b0;
    endtask

    task automatic ignored_pulse();
        logic [7:0] o_sdo, o_oe;
        logic [CHW-1:0] o_tc;
        @(negedge clk);
        o_sdo = sdo; o_oe = sdo_oe; o_tc = tx_chan;
        if (use_ext) int_tick = 1'b1; else ext_tick = 1'b1;
        @(negedge clk);
        int_tick = 1'b0; ext_tick = 1'b0;
        check(sdo == o_sdo && sdo_oe == o_oe && tx_chan == o_tc && rx_valid == '0,
              "R8", "unselected tick moved the port", int'(tx_chan), int'(o_tc));
    endtask

    bit done = 1'b0;

    initial begin
        int rates [5] = '{0, 1, 2, 1, 0};
        void'($urandom(32'h1d5a_7e03));
        for (int c = 0; c < 128; c++) bdir[c] = '0;
        repeat (3) @(negedge clk);
        check(sdo_oe == '0, "R7", "oe in reset", int'(sdo_oe), 0);
        check(rx_valid == '0, "R7", "rx_valid in reset", int'(rx_valid), 0);
        rst = 1'b0;
        // Ticks with the reset-state table and then a programmed table, no frame pulse yet
        repeat (12) do_tick(1'b0);
        write_dirs();
        repeat (20) do_tick(1'b0);
        for (int p = 0; p < 5; p++) begin
            int n;
            if (p == 1) begin ref_en = 1'b1; int_clk = 1'b0; use_ext = 1'b1; end
            if (p == 3) begin int_clk = 1'b1; use_ext = 1'b0; end
            rate = 2'(rates[p]);
            txsalt = int'($urandom % 1000);
            write_dirs();
            if (p == 0) begin
                // directed: line 0 output everywhere, line 7 input everywhere
                for (int c = 0; c < 128; c++) begin
                    bdir[c][0] = 1'b1; bdir[c][7] = 1'b0;
                    @(negedge clk);
                    dir_we = 1'b1; dir_chan = CHW'(c); dir_lines = bdir[c];
                end
                @(negedge clk);
                dir_we = 1'b0;
            end
            do_tick(1'b1);
            rxsalt = int'($urandom % 1000);
            n = exp_chans(brate) * 8;
            // R1: first frame, then a free-running frame that must wrap alone
            repeat (n - 1) do_tick(1'b0);
            repeat (n) do_tick(1'b0);
            // R1: next rate presented early; must wait for the frame pulse
            if (p < 4) rate = 2'(rates[p + 1]);
            repeat (5 * 8 + 3) do_tick(1'b0);
            ignored_pulse();
            ignored_pulse();
        end
        do_tick(1'b1);
        repeat (40) do_tick(1'b0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule